// File: doc/BRIEF.md
# Four-Channel Shared-Period PWM Timer

The block is an up-counting timer that feeds several pulse-width outputs from one common time base. A prescaler divides the input clock by (prescaler + 1) to produce counter steps, and the counter runs from 0 up to the active reload value before wrapping. Each channel compares the counter with its own compare value and produces a main output plus a complementary output. Each output has its own enable and polarity bit, and one master output-enable gates all of them.

Software programs the timer through a plain single-cycle write port. Every write is taken in the cycle it is presented, so there is no back-pressure and no handshake. The prescaler and the compare values are always buffered in shadow copies. The reload value is buffered only when reload preloading is on. The buffered values reach the active copies at a counter wrap or at a software update event, so a period never mixes old and new settings. A one-cycle update pulse marks the first cycle of every period.

The register map uses word addresses on `cfg_addr`:
- Address 0 is control: bit 0 runs the counter, bit 1 turns on reload preloading, and bit 2 is the master output enable.
- A write of any data to address 1 is the update event.
- Address 2 holds the prescaler.
- Address 3 holds the reload value.
- Addresses 4 to 7 hold the compare values of channels 0 to 3.
- Address 8 holds the channel configuration. Channel i owns bits 4i+3 down to 4i: bit 0 of the nibble enables the main output, bit 1 inverts it, bit 2 enables the complementary output, and bit 3 inverts that output.

Top module: `pwm_quad_timer`

## Requirements
- R1: After reset, every main and complementary output is low, `upd_o` is low, and the counter is stopped.
- R2: While running, a period lasts (prescaler + 1) × (reload + 1) clocks, and `upd_o` is high for exactly the first clock of each period.
- R3: When a main output is enabled and not inverted, it is high from the start of the period for compare × (prescaler + 1) clocks. A compare of 0 keeps it low, and a compare of reload + 1 keeps it high for the whole period.
- R4: With the main polarity bit set, the output is high for (reload + 1 − compare) × (prescaler + 1) clocks, starting compare × (prescaler + 1) clocks into the period.
- R5: An enabled complementary output carries the inverse of the channel's uninverted compare result, further inverted by its own polarity bit, whatever the main polarity is.
- R6: With the master output enable clear, every output sits at its inactive level, which equals its own polarity bit. A channel output whose own enable is clear does the same.
- R7: Writes to the prescaler (address 2) or to a compare value (addresses 4 to 7) leave the outputs and the running period unchanged until the next wrap or update event.
- R8: With reload preloading on (control bit 1), a reload write takes effect at the next wrap or update event. With it off, the write takes effect in the current period.
- R9: A write to address 1 loads all buffered values into the active copies and restarts the prescaler and counter at zero. `upd_o` is high in the following clock, even when the counter is stopped.
- R10: With control bit 0 clear, the counter and prescaler hold their values, no `upd_o` pulse occurs apart from update events, and the outputs stay steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe, taken in the cycle it is high |
| cfg_addr | input | 4 | Word address of the register being written |
| cfg_wdata | input | 32 | Write data |
| pwm_o | output | 4 | Main channel outputs, channel i on bit i |
| pwm_n_o | output | 4 | Complementary channel outputs, channel i on bit i |
| upd_o | output | 1 | One-cycle pulse in the first clock of each period |

## Verification
The checker assumes that reset is held low across at least one clock edge. It also assumes that the compare and reload values leave reload + 1 within the counter width, so a full-duty compare means what it says. Its full-duty property applies only while the counter is at or below the active reload value, because a reload lowered without preloading can leave the counter above it for a moment. The stimulus keeps the reload at 19 or below and the prescaler at 1 or below. It makes mid-period writes only after the monitor has seen the start of a period, and early enough that the counter is still far from the reload value when they land.

// File: rtl/pwm_qt_pkg.sv
package pwm_qt_pkg;
  // Word addresses of the write port.
  localparam int CTRL_ADDR  = 0;
  localparam int UPD_ADDR   = 1;
  localparam int PSC_ADDR   = 2;
  localparam int ARR_ADDR   = 3;
  localparam int CCR_BASE   = 4;
  localparam int CHCFG_ADDR = 8;

  // Control word bit positions.
  localparam int RUN_BIT  = 0;
  localparam int ARPE_BIT = 1;
  localparam int MOE_BIT  = 2;

  // Per-channel configuration nibble.
  localparam int CH_CFG_W = 4;

  typedef struct packed {
    logic comp_pol;
    logic comp_en;
    logic pol;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_qt_regs.sv
module pwm_qt_regs
  import pwm_qt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic                       run_o,
  output logic                       arpe_o,
  output logic                       moe_o,
  output logic                       ug_o,
  output logic [PSC_W-1:0]           psc_pre_o,
  output logic [CNT_W-1:0]           arr_pre_o,
  output logic                       arr_direct_we_o,
  output logic [NUM_CH*CNT_W-1:0]    ccr_pre_o,
  output logic [NUM_CH*CH_CFG_W-1:0] chcfg_o
);
  localparam int CFG_BITS = NUM_CH * CH_CFG_W;

  logic wr_arr;
  assign wr_arr          = we && (addr == ADDR_W'(ARR_ADDR));
  assign ug_o            = we && (addr == ADDR_W'(UPD_ADDR));
  assign arr_direct_we_o = wr_arr && !arpe_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o     <= 1'b0;
      arpe_o    <= 1'b0;
      moe_o     <= 1'b0;
      psc_pre_o <= '0;
      arr_pre_o <= '0;
      chcfg_o   <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(CTRL_ADDR)) begin
        run_o  <= wdata[RUN_BIT];
        arpe_o <= wdata[ARPE_BIT];
        moe_o  <= wdata[MOE_BIT];
      end
      if (addr == ADDR_W'(PSC_ADDR))   psc_pre_o <= wdata[PSC_W-1:0];
      if (wr_arr)                      arr_pre_o <= wdata[CNT_W-1:0];
      if (addr == ADDR_W'(CHCFG_ADDR)) chcfg_o   <= wdata[CFG_BITS-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ccr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ccr_pre_o[i*CNT_W +: CNT_W] <= '0;
      else if (we && addr == ADDR_W'(CCR_BASE + i))
        ccr_pre_o[i*CNT_W +: CNT_W] <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_qt_timebase.sv
module pwm_qt_timebase #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ug,
  input  logic [PSC_W-1:0] psc_pre,
  input  logic [CNT_W-1:0] arr_pre,
  input  logic             arr_direct_we,
  input  logic [CNT_W-1:0] arr_direct_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PSC_W-1:0] psc_act_o,
  output logic [CNT_W-1:0] arr_act_o,
  output logic             load_o,
  output logic             upd_o
);
  logic [PSC_W-1:0] psc_cnt;
  logic             tick;
  logic             wrap;

  assign tick   = psc_cnt >= psc_act_o;
  // Compare with >= so that a reload lowered on the fly still wraps.
  assign wrap   = run && tick && (cnt_o >= arr_act_o);
  assign load_o = ug || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      cnt_o   <= '0;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= load_o;
      if (ug) begin
        psc_cnt <= '0;
        cnt_o   <= '0;
      end else if (run) begin
        if (tick) begin
          psc_cnt <= '0;
          cnt_o   <= wrap ? '0 : cnt_o + 1'b1;
        end else begin
          psc_cnt <= psc_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_act_o <= '0;
      arr_act_o <= '0;
    end else begin
      if (load_o) psc_act_o <= psc_pre;
      if (arr_direct_we)
        arr_act_o <= arr_direct_val;
      else if (load_o)
        arr_act_o <= arr_pre;
    end
  end
endmodule

// File: rtl/pwm_qt_channel.sv
module pwm_qt_channel
  import pwm_qt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CNT_W-1:0]    ccr_pre,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                moe,
  input  logic [CH_CFG_W-1:0] cfg,
  output logic [CNT_W-1:0]    ccr_act_o,
  output logic                pwm_o,
  output logic                pwm_n_o
);
  chan_cfg_t cfg_s;
  logic      raw;

  assign cfg_s = chan_cfg_t'(cfg);

  always_ff @(posedge clk) begin
    if (!rst_n)    ccr_act_o <= '0;
    else if (load) ccr_act_o <= ccr_pre;
  end

  // Active while the counter is below the compare value.
  assign raw     = cnt < ccr_act_o;
  assign pwm_o   = (moe && cfg_s.en)      ? (raw ^ cfg_s.pol)       : cfg_s.pol;
  assign pwm_n_o = (moe && cfg_s.comp_en) ? (~raw ^ cfg_s.comp_pol) : cfg_s.comp_pol;
endmodule

// File: rtl/pwm_quad_timer.sv
module pwm_quad_timer
  import pwm_qt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwm_n_o,
  output logic              upd_o
);
  localparam int CCR_BITS = NUM_CH * CNT_W;
  localparam int CFG_BITS = NUM_CH * CH_CFG_W;

  logic                run, arpe, moe, ug, arr_direct_we, load;
  logic [PSC_W-1:0]    psc_pre, psc_act;
  logic [CNT_W-1:0]    arr_pre, arr_act, cnt;
  logic [CCR_BITS-1:0] ccr_pre, ccr_act;
  logic [CFG_BITS-1:0] chcfg;

  pwm_qt_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .run_o(run), .arpe_o(arpe), .moe_o(moe), .ug_o(ug),
    .psc_pre_o(psc_pre), .arr_pre_o(arr_pre), .arr_direct_we_o(arr_direct_we),
    .ccr_pre_o(ccr_pre), .chcfg_o(chcfg)
  );

  pwm_qt_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .ug(ug),
    .psc_pre(psc_pre), .arr_pre(arr_pre),
    .arr_direct_we(arr_direct_we), .arr_direct_val(cfg_wdata[CNT_W-1:0]),
    .cnt_o(cnt), .psc_act_o(psc_act), .arr_act_o(arr_act),
    .load_o(load), .upd_o(upd_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_qt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(load),
      .ccr_pre(ccr_pre[i*CNT_W +: CNT_W]), .cnt(cnt), .moe(moe),
      .cfg(chcfg[i*CH_CFG_W +: CH_CFG_W]),
      .ccr_act_o(ccr_act[i*CNT_W +: CNT_W]),
      .pwm_o(pwm_o[i]), .pwm_n_o(pwm_n_o[i])
    );
  end
endmodule

// File: rtl/pwm_quad_timer_sva.sv
module pwm_quad_timer_sva
  import pwm_qt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       run,
  input logic                       ug,
  input logic                       moe,
  input logic                       load,
  input logic                       arr_direct_we,
  input logic [CNT_W-1:0]           cnt,
  input logic [PSC_W-1:0]           psc_act,
  input logic [CNT_W-1:0]           arr_act,
  input logic [NUM_CH*CNT_W-1:0]    ccr_act,
  input logic [NUM_CH*CH_CFG_W-1:0] chcfg,
  input logic [NUM_CH-1:0]          pwm_o,
  input logic [NUM_CH-1:0]          pwm_n_o,
  input logic                       upd_o
);
  // R2: the update pulse marks the counter's zero state.
  a_r2_upd_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> cnt == '0);

  // R9: an update event restarts the count and pulses upd_o.
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0 && upd_o));

  // R10: a stopped counter holds unless an update event arrives.
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(cnt));

  // R7: the active prescaler changes only at a load.
  a_r7_psc_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(psc_act));

  // R8: the active reload changes only at a load or a direct write.
  a_r8_arr_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !arr_direct_we) |=> $stable(arr_act));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chan_cfg_t c;
    assign c = chan_cfg_t'(chcfg[i*CH_CFG_W +: CH_CFG_W]);

    // R7: the active compare changes only at a load.
    a_r7_ccr_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ccr_act[i*CNT_W +: CNT_W]));

    // R3: a compare above the reload gives a full-duty output.
    a_r3_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && c.en && !c.pol && cnt <= arr_act &&
       ccr_act[i*CNT_W +: CNT_W] > arr_act) |-> pwm_o[i]);

    // R6: with the master enable off, outputs rest at their polarity.
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !moe |-> (pwm_o[i] == c.pol && pwm_n_o[i] == c.comp_pol));

    // R5: the complementary output is the opposite phase of the main one.
    a_r5_opposite: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && c.en && c.comp_en) |-> ((pwm_o[i] ^ c.pol) != (pwm_n_o[i] ^ c.comp_pol)));
  end
endmodule

bind pwm_quad_timer pwm_quad_timer_sva #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PSC_W(PSC_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .ug(ug), .moe(moe), .load(load),
  .arr_direct_we(arr_direct_we), .cnt(cnt), .psc_act(psc_act), .arr_act(arr_act),
  .ccr_act(ccr_act), .chcfg(chcfg), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .upd_o(upd_o)
);

// File: tb/pwm_quad_timer_test.sv
`timescale 1ns/1ps
module pwm_quad_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  pwm_o, pwm_n_o;
  logic        upd_o;

  always #4 clk = ~clk;

  pwm_quad_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .upd_o(upd_o)
  );

  typedef struct {
    int period;
    int hi[8];
    int first[8];
  } item_t;

  item_t sb_q[$];
  string tag_q[$];
  logic  mon_started = 1'b0;
  int    checks = 0;
  int    failures = 0;

  // Bench model of the programmed settings.
  int          m_psc, m_arr;
  int          m_ccr[4];
  logic [15:0] m_cfg;
  logic        m_moe;

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Output vector {complementary, main} for counter value k, from R3..R6.
  function automatic logic [7:0] out_at(int k);
    logic [7:0] v;
    for (int ch = 0; ch < 4; ch++) begin
      logic raw;
      raw = k < m_ccr[ch];
      v[ch]     = (m_moe && m_cfg[4*ch])   ? (raw ^ m_cfg[4*ch+1])  : m_cfg[4*ch+1];
      v[4 + ch] = (m_moe && m_cfg[4*ch+2]) ? (!raw ^ m_cfg[4*ch+3]) : m_cfg[4*ch+3];
    end
    return v;
  endfunction

  function automatic item_t build();
    item_t it;
    it.period = (m_psc + 1) * (m_arr + 1);
    for (int j = 0; j < 8; j++) begin it.hi[j] = 0; it.first[j] = -1; end
    for (int k = 0; k <= m_arr; k++) begin
      logic [7:0] v;
      v = out_at(k);
      for (int j = 0; j < 8; j++) begin
        if (v[j]) begin
          if (it.first[j] < 0) it.first[j] = k * (m_psc + 1);
          it.hi[j] += m_psc + 1;
        end
      end
    end
    return it;
  endfunction

  task automatic push(input string tag);
    sb_q.push_back(build());
    tag_q.push_back(tag);
  endtask

  // Monitor: measures one whole period per queued item and compares.
  initial begin
    item_t      it;
    string      tag;
    int         len;
    int         hi[8];
    int         first[8];
    logic [7:0] v;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q[0];
      tag = tag_q[0];
      @(negedge clk);
      while (!upd_o) @(negedge clk);
      mon_started = 1'b1;
      for (int j = 0; j < 8; j++) begin hi[j] = 0; first[j] = -1; end
      len = 0;
      do begin
        v = {pwm_n_o, pwm_o};
        for (int j = 0; j < 8; j++) begin
          if (v[j]) begin
            if (first[j] < 0) first[j] = len;
            hi[j]++;
          end
        end
        len++;
        @(negedge clk);
      end while (!upd_o && len < 4 * it.period);
      check($sformatf("R2 period length [%s]", tag), len, it.period);
      for (int j = 0; j < 8; j++) begin
        check($sformatf("%s out%0d high clocks", tag, j), hi[j], it.hi[j]);
        check($sformatf("%s out%0d first high", tag, j), first[j], it.first[j]);
      end
      mon_started = 1'b0;
      void'(sb_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: got 1 expected 0");
    finish_run();
  end

  initial begin
    logic [7:0] snap;
    int         n_upd, n_chg;

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 outputs after reset", int'({pwm_n_o, pwm_o}), 0);
      check("R1 upd_o after reset", int'(upd_o), 0);
    end

    m_psc = 1; m_arr = 9;
    m_ccr[0] = 3; m_ccr[1] = 0; m_ccr[2] = 10; m_ccr[3] = 4;
    m_cfg = 16'h7D95; m_moe = 1'b1;
    wr(2, m_psc); wr(3, m_arr);
    for (int c = 0; c < 4; c++) wr(4 + c, m_ccr[c]);
    wr(8, int'(m_cfg));
    wr(0, 5);
    wr(1, 0);
    // R3 R4 R5 R6: mixed duties, polarities, a disabled complementary output.
    push("R3 R4 R5 R6 mixed");
    wait (sb_q.size() == 0);

    // R6: master enable off, counter still running.
    m_moe = 1'b0;
    wr(0, 1);
    push("R6 master off");
    wait (sb_q.size() == 0);

    // R7: prescaler and compare writes mid-period wait for the wrap.
    m_moe = 1'b1;
    wr(0, 5);
    push("R7 old settings");
    wait (mon_started);
    wr(2, 0); wr(4, 7);
    m_psc = 0; m_ccr[0] = 7;
    push("R7 new settings");
    wait (sb_q.size() == 0);

    // R8: reload without preloading applies in the current period.
    m_arr = 19;
    push("R8 direct reload");
    wait (mon_started);
    wr(3, 19);
    wait (sb_q.size() == 0);

    // R8: reload with preloading waits for the wrap.
    wr(0, 7);
    push("R8 preload old");
    wait (mon_started);
    wr(3, 9);
    m_arr = 9;
    push("R8 preload new");
    wait (sb_q.size() == 0);

    // R10: stopped counter holds.
    wr(0, 6);
    @(negedge clk); @(negedge clk);
    snap = {pwm_n_o, pwm_o};
    n_upd = 0; n_chg = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd_o) n_upd++;
      if ({pwm_n_o, pwm_o} !== snap) n_chg++;
    end
    check("R10 update pulses while stopped", n_upd, 0);
    check("R10 output changes while stopped", n_chg, 0);

    // R7: a compare write alone does not reach the outputs.
    wr(4, 2);
    m_ccr[0] = 2;
    check("R7 outputs after compare write", int'({pwm_n_o, pwm_o}), int'(snap));

    // R9: update event while stopped.
    wr(1, 0);
    check("R9 upd_o after update event", int'(upd_o), 1);
    check("R9 outputs at count zero", int'({pwm_n_o, pwm_o}), int'(out_at(0)));
    @(negedge clk);
    check("R9 single pulse when stopped", int'(upd_o), 0);
    check("R10 outputs held after update", int'({pwm_n_o, pwm_o}), int'(out_at(0)));

    wr(0, 7);
    push("R9 settings after update");
    wait (sb_q.size() == 0);

    finish_run();
  end
endmodule